// File: doc/BRIEF.md
# Dual-Clock Mailbox Exchange

This block gives two independently clocked ports a direct path for single words that bypasses any queue. One mailbox carries a word from port A to port B and a second carries a word from port B to port A. Each mailbox has a flag that is low while it holds an unread word. The writing port's clock drives the flag low. A qualifying read on the other port's clock drives it high again.

Each port presents the usual chip-select, enable and read/write inputs. An access happens on a rising edge only when chip select is low and enable is high. Port A chooses the mailbox with a dedicated select input. Port B chooses it when both of its two bus-size bits are high; other size codes belong to a data path that is not part of this block. Set and clear events cross between the two clock domains as toggles, each through a synchronizer chain. Every event therefore arrives, and the contents of a held word never change while the other side may be reading it.

Top module: `mbox_xchg`

## Requirements
- R1: After reset on both ports, both mailbox flags are high and both data outputs read zero.
- R2: A port A rising edge with a_cs_n=0, a_en=1, a_wr=1 and a_mbsel=1, while mailbox 1 is free as seen by port A, stores a_din into mailbox 1 (visible on b_dout) and drives mb1_flag_n low.
- R3: A port A write to mailbox 1 while mb1_flag_n is low is discarded: b_dout keeps the stored word.
- R4: A port B rising edge with b_cs_n=0, b_en=1, b_wr=0 and b_siz=2'b11, once the set of mailbox 1 has crossed to port B, drives mb1_flag_n high.
- R5: A port B read with b_siz other than 2'b11 leaves mb1_flag_n low.
- R6: A port B rising edge with b_cs_n=0, b_en=1, b_wr=1 and b_siz=2'b11, while mailbox 2 is free as seen by port B, stores b_din into mailbox 2 (visible on a_dout) and drives mb2_flag_n low. A port B write with any other b_siz leaves the flag high.
- R7: A port B write to mailbox 2 while mb2_flag_n is low is discarded: a_dout keeps the stored word.
- R8: A port A read (a_wr=0) with a_mbsel=1, once the set of mailbox 2 has crossed to port A, drives mb2_flag_n high. The same read with a_mbsel=0 leaves it low.
- R9: On either port, an edge with chip select high or enable low performs no access: no flag changes.
- R10: a_dout_en is high exactly when a_cs_n=0 and a_wr=0, and b_dout_en is high exactly when b_cs_n=0 and b_wr=0. The enables do not depend on the clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_a | input | 1 | Port A clock |
| rst_a | input | 1 | Port A synchronous reset, active high |
| a_cs_n | input | 1 | Port A chip select, active low |
| a_en | input | 1 | Port A access enable |
| a_wr | input | 1 | Port A direction: 1 write, 0 read |
| a_mbsel | input | 1 | Port A mailbox select |
| a_din | input | DW | Word written into mailbox 1 |
| a_dout | output | DW | Contents of mailbox 2 |
| a_dout_en | output | 1 | Port A output drive enable |
| clk_b | input | 1 | Port B clock |
| rst_b | input | 1 | Port B synchronous reset, active high |
| b_cs_n | input | 1 | Port B chip select, active low |
| b_en | input | 1 | Port B access enable |
| b_wr | input | 1 | Port B direction: 1 write, 0 read |
| b_siz | input | 2 | Port B bus size; 2'b11 selects the mailbox |
| b_din | input | DW | Word written into mailbox 2 |
| b_dout | output | DW | Contents of mailbox 1 |
| b_dout_en | output | 1 | Port B output drive enable |
| mb1_flag_n | output | 1 | Mailbox 1 flag, low while a word is held |
| mb2_flag_n | output | 1 | Mailbox 2 flag, low while a word is held |

## Verification
The bench builds the block with DW=12 and STAGES=3. It runs port A at 125 MHz and port B on a slower, unrelated period. The narrow word lets every stored value be a walking one or a walking zero, so each data bit is shown to travel alone in both directions and to resist an overwrite by its complement. Three synchronizer stages exercise the depth parameter away from its default. The sweep also rotates through every non-mailbox size code and both kinds of gated-off access.

// File: rtl/mbox_pkg.sv
package mbox_pkg;

    localparam int unsigned SIZ_W       = 2;
    localparam logic [SIZ_W-1:0] SIZ_MAILBOX = 2'b11;

    typedef struct packed {
        logic cs_n;
        logic en;
        logic wr;
    } port_cmd_t;

    typedef struct packed {
        logic put;
        logic take;
    } mbox_req_t;

    function automatic logic cmd_live(input port_cmd_t c);
        return !c.cs_n && c.en;
    endfunction

    function automatic logic cmd_drive(input port_cmd_t c);
        return !c.cs_n && !c.wr;
    endfunction

    function automatic logic size_picks_mbox(input logic [SIZ_W-1:0] siz);
        return siz == SIZ_MAILBOX;
    endfunction

    function automatic mbox_req_t decode_req(input port_cmd_t c, input logic sel);
        mbox_req_t r;
        r.put  = cmd_live(c) && sel && c.wr;
        r.take = cmd_live(c) && sel && !c.wr;
        return r;
    endfunction

    // A mailbox holds a word while the two toggles differ.
    function automatic logic toggles_differ(input logic x, input logic y);
        return x ^ y;
    endfunction

endpackage

// File: rtl/mbox_sync.sv
module mbox_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic chain [STAGES];

    for (genvar i = 0; i < STAGES; i++) begin : g_stage
        if (i == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) chain[0] <= 1'b0;
                else     chain[0] <= d;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) chain[i] <= 1'b0;
                else     chain[i] <= chain[i-1];
            end
        end
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/mbox_lane.sv
module mbox_lane
    import mbox_pkg::*;
#(
    parameter int unsigned DW     = 36,
    parameter int unsigned STAGES = 2
) (
    input  logic          wclk,
    input  logic          wrst,
    input  logic          put_req,
    input  logic [DW-1:0] put_data,
    input  logic          rclk,
    input  logic          rrst,
    input  logic          take_req,
    output logic [DW-1:0] held,
    output logic          flag_n
);
    logic w_tgl;
    logic r_tgl;
    logic r_tgl_at_w;
    logic w_tgl_at_r;
    logic w_sees_full;
    logic r_sees_full;

    mbox_sync #(.STAGES(STAGES)) u_clr_to_w (
        .clk (wclk),
        .rst (wrst),
        .d   (r_tgl),
        .q   (r_tgl_at_w)
    );

    mbox_sync #(.STAGES(STAGES)) u_set_to_r (
        .clk (rclk),
        .rst (rrst),
        .d   (w_tgl),
        .q   (w_tgl_at_r)
    );

    assign w_sees_full = toggles_differ(w_tgl, r_tgl_at_w);
    assign r_sees_full = toggles_differ(w_tgl_at_r, r_tgl);

    always_ff @(posedge wclk) begin
        if (wrst) begin
            w_tgl <= 1'b0;
            held  <= '0;
        end else if (put_req && !w_sees_full) begin
            w_tgl <= ~w_tgl;
            held  <= put_data;
        end
    end

    always_ff @(posedge rclk) begin
        if (rrst)                         r_tgl <= 1'b0;
        else if (take_req && r_sees_full) r_tgl <= ~r_tgl;
    end

    assign flag_n = !toggles_differ(w_tgl, r_tgl);
endmodule

// File: rtl/mbox_xchg.sv
module mbox_xchg
    import mbox_pkg::*;
#(
    parameter int unsigned DW     = 36,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk_a,
    input  logic             rst_a,
    input  logic             a_cs_n,
    input  logic             a_en,
    input  logic             a_wr,
    input  logic             a_mbsel,
    input  logic [DW-1:0]    a_din,
    output logic [DW-1:0]    a_dout,
    output logic             a_dout_en,
    input  logic             clk_b,
    input  logic             rst_b,
    input  logic             b_cs_n,
    input  logic             b_en,
    input  logic             b_wr,
    input  logic [SIZ_W-1:0] b_siz,
    input  logic [DW-1:0]    b_din,
    output logic [DW-1:0]    b_dout,
    output logic             b_dout_en,
    output logic             mb1_flag_n,
    output logic             mb2_flag_n
);
    port_cmd_t a_cmd;
    port_cmd_t b_cmd;
    mbox_req_t a_req;
    mbox_req_t b_req;

    assign a_cmd = '{cs_n: a_cs_n, en: a_en, wr: a_wr};
    assign b_cmd = '{cs_n: b_cs_n, en: b_en, wr: b_wr};

    assign a_req = decode_req(a_cmd, a_mbsel);
    assign b_req = decode_req(b_cmd, size_picks_mbox(b_siz));

    assign a_dout_en = cmd_drive(a_cmd);
    assign b_dout_en = cmd_drive(b_cmd);

    // Mailbox 1: written on port A, read on port B.
    mbox_lane #(.DW(DW), .STAGES(STAGES)) u_lane_ab (
        .wclk     (clk_a),
        .wrst     (rst_a),
        .put_req  (a_req.put),
        .put_data (a_din),
        .rclk     (clk_b),
        .rrst     (rst_b),
        .take_req (b_req.take),
        .held     (b_dout),
        .flag_n   (mb1_flag_n)
    );

    // Mailbox 2: written on port B, read on port A.
    mbox_lane #(.DW(DW), .STAGES(STAGES)) u_lane_ba (
        .wclk     (clk_b),
        .wrst     (rst_b),
        .put_req  (b_req.put),
        .put_data (b_din),
        .rclk     (clk_a),
        .rrst     (rst_a),
        .take_req (a_req.take),
        .held     (a_dout),
        .flag_n   (mb2_flag_n)
    );
endmodule

// File: rtl/mbox_xchg_chk.sv
module mbox_xchg_chk #(
    parameter int unsigned DW     = 36,
    parameter int unsigned STAGES = 2
) (
    input logic          clk_a,
    input logic          rst_a,
    input logic          a_cs_n,
    input logic          a_en,
    input logic          a_wr,
    input logic          a_mbsel,
    input logic [DW-1:0] a_din,
    input logic [DW-1:0] a_dout,
    input logic          clk_b,
    input logic          rst_b,
    input logic          b_cs_n,
    input logic          b_en,
    input logic          b_wr,
    input logic [1:0]    b_siz,
    input logic [DW-1:0] b_din,
    input logic [DW-1:0] b_dout,
    input logic          mb1_flag_n,
    input logic          mb2_flag_n
);
    localparam int unsigned CW = $clog2(STAGES + 2) + 1;

    logic a_put, a_take, b_put, b_take;
    assign a_put  = !a_cs_n && a_en && a_mbsel && a_wr;
    assign a_take = !a_cs_n && a_en && a_mbsel && !a_wr;
    assign b_put  = !b_cs_n && b_en && (b_siz == 2'b11) && b_wr;
    assign b_take = !b_cs_n && b_en && (b_siz == 2'b11) && !b_wr;

    // Consecutive edges on which a flag has kept one level, per domain.
    logic [CW-1:0] a_mb1_hi, a_mb2_lo, b_mb1_lo, b_mb2_hi;

    always_ff @(posedge clk_a) begin
        if (rst_a) begin
            a_mb1_hi <= '0;
            a_mb2_lo <= '0;
        end else begin
            a_mb1_hi <= !mb1_flag_n ? '0 : (a_mb1_hi >= CW'(STAGES) ? a_mb1_hi : a_mb1_hi + 1'b1);
            a_mb2_lo <=  mb2_flag_n ? '0 : (a_mb2_lo >= CW'(STAGES) ? a_mb2_lo : a_mb2_lo + 1'b1);
        end
    end

    always_ff @(posedge clk_b) begin
        if (rst_b) begin
            b_mb1_lo <= '0;
            b_mb2_hi <= '0;
        end else begin
            b_mb1_lo <=  mb1_flag_n ? '0 : (b_mb1_lo >= CW'(STAGES) ? b_mb1_lo : b_mb1_lo + 1'b1);
            b_mb2_hi <= !mb2_flag_n ? '0 : (b_mb2_hi >= CW'(STAGES) ? b_mb2_hi : b_mb2_hi + 1'b1);
        end
    end

    // R2
    mb1_store_chk: assert property (@(posedge clk_a) disable iff (rst_a || rst_b)
        (a_put && mb1_flag_n && a_mb1_hi >= CW'(STAGES)) |=> (b_dout == $past(a_din)));

    // R3
    mb1_hold_chk: assert property (@(posedge clk_a) disable iff (rst_a || rst_b)
        (a_put && !mb1_flag_n) |=> $stable(b_dout));

    // R4
    mb1_clear_chk: assert property (@(posedge clk_b) disable iff (rst_a || rst_b)
        (b_take && !mb1_flag_n && b_mb1_lo >= CW'(STAGES)) |=> mb1_flag_n);

    // R6
    mb2_store_chk: assert property (@(posedge clk_b) disable iff (rst_a || rst_b)
        (b_put && mb2_flag_n && b_mb2_hi >= CW'(STAGES)) |=> (a_dout == $past(b_din)));

    // R7
    mb2_hold_chk: assert property (@(posedge clk_b) disable iff (rst_a || rst_b)
        (b_put && !mb2_flag_n) |=> $stable(a_dout));

    // R8
    mb2_clear_chk: assert property (@(posedge clk_a) disable iff (rst_a || rst_b)
        (a_take && !mb2_flag_n && a_mb2_lo >= CW'(STAGES)) |=> mb2_flag_n);
endmodule

bind mbox_xchg mbox_xchg_chk #(.DW(DW), .STAGES(STAGES)) u_mbox_xchg_chk (
    .clk_a      (clk_a),
    .rst_a      (rst_a),
    .a_cs_n     (a_cs_n),
    .a_en       (a_en),
    .a_wr       (a_wr),
    .a_mbsel    (a_mbsel),
    .a_din      (a_din),
    .a_dout     (a_dout),
    .clk_b      (clk_b),
    .rst_b      (rst_b),
    .b_cs_n     (b_cs_n),
    .b_en       (b_en),
    .b_wr       (b_wr),
    .b_siz      (b_siz),
    .b_din      (b_din),
    .b_dout     (b_dout),
    .mb1_flag_n (mb1_flag_n),
    .mb2_flag_n (mb2_flag_n)
);

// File: tb/test_mbox_xchg.sv
module test_mbox_xchg;
    localparam int unsigned DW     = 12;
    localparam int unsigned STAGES = 3;
    localparam int unsigned XWAIT  = STAGES + 2;

    logic          clk_a = 1'b0;
    logic          clk_b = 1'b0;
    logic          rst_a = 1'b1;
    logic          rst_b = 1'b1;
    logic          a_cs_n = 1'b1, a_en = 1'b0, a_wr = 1'b0, a_mbsel = 1'b0;
    logic [DW-1:0] a_din = '0;
    logic [DW-1:0] a_dout;
    logic          a_dout_en;
    logic          b_cs_n = 1'b1, b_en = 1'b0, b_wr = 1'b0;
    logic [1:0]    b_siz = 2'b00;
    logic [DW-1:0] b_din = '0;
    logic [DW-1:0] b_dout;
    logic          b_dout_en;
    logic          mb1_flag_n, mb2_flag_n;

    int unsigned nvec = 0;
    int unsigned nbad = 0;
    bit          done = 1'b0;

    always #4 clk_a = ~clk_a;
    always #7 clk_b = ~clk_b;

    mbox_xchg #(.DW(DW), .STAGES(STAGES)) i_mbox_xchg (
        .clk_a, .rst_a, .a_cs_n, .a_en, .a_wr, .a_mbsel, .a_din, .a_dout, .a_dout_en,
        .clk_b, .rst_b, .b_cs_n, .b_en, .b_wr, .b_siz, .b_din, .b_dout, .b_dout_en,
        .mb1_flag_n, .mb2_flag_n
    );

    task automatic chk(input bit ok, input string rq, input logic [63:0] act, input logic [63:0] exp);
        nvec++;
        if (!ok) begin
            nbad++;
            $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
        end
    endtask

    task automatic a_op(input logic cs_n, input logic en, input logic wr, input logic sel, input logic [DW-1:0] d);
        @(negedge clk_a);
        a_cs_n = cs_n; a_en = en; a_wr = wr; a_mbsel = sel; a_din = d;
        @(negedge clk_a);
        a_cs_n = 1'b1; a_en = 1'b0; a_wr = 1'b0; a_mbsel = 1'b0;
    endtask

    task automatic b_op(input logic cs_n, input logic en, input logic wr, input logic [1:0] siz, input logic [DW-1:0] d);
        @(negedge clk_b);
        b_cs_n = cs_n; b_en = en; b_wr = wr; b_siz = siz; b_din = d;
        @(negedge clk_b);
        b_cs_n = 1'b1; b_en = 1'b0; b_wr = 1'b0; b_siz = 2'b00;
    endtask

    task automatic wait_a(input int n);
        repeat (n) @(negedge clk_a);
    endtask

    task automatic wait_b(input int n);
        repeat (n) @(negedge clk_b);
    endtask

    task automatic drive_en_probe();
        @(negedge clk_a);
        a_cs_n = 1'b0; a_wr = 1'b0; #1;
        chk(a_dout_en === 1'b1, "R10 a read", a_dout_en, 1);
        a_wr = 1'b1; #1;
        chk(a_dout_en === 1'b0, "R10 a write", a_dout_en, 0);
        a_cs_n = 1'b1; a_wr = 1'b0; #1;
        chk(a_dout_en === 1'b0, "R10 a deselected", a_dout_en, 0);
        b_cs_n = 1'b0; b_wr = 1'b0; #1;
        chk(b_dout_en === 1'b1, "R10 b read", b_dout_en, 1);
        b_wr = 1'b1; #1;
        chk(b_dout_en === 1'b0, "R10 b write", b_dout_en, 0);
        b_cs_n = 1'b1; b_wr = 1'b0; #1;
        chk(b_dout_en === 1'b0, "R10 b deselected", b_dout_en, 0);
    endtask

    initial begin
        wait_a(4);
        wait_b(4);
        @(negedge clk_a) rst_a = 1'b0;
        @(negedge clk_b) rst_b = 1'b0;
        wait_a(2);
        chk(mb1_flag_n === 1'b1, "R1 mb1 flag", mb1_flag_n, 1);
        chk(mb2_flag_n === 1'b1, "R1 mb2 flag", mb2_flag_n, 1);
        chk(a_dout === '0, "R1 a_dout", a_dout, 0);
        chk(b_dout === '0, "R1 b_dout", b_dout, 0);

        for (int k = 0; k < 2 * DW; k++) begin
            logic [DW-1:0] d;
            logic [DW-1:0] e;
            logic          bad_cs;
            logic [1:0]    other_siz;
            d = (k < DW) ? (DW'(1) << k) : ~(DW'(1) << (k - DW));
            e = ~d;
            bad_cs = k[0];
            other_siz = 2'(k % 3);

            drive_en_probe();

            // Mailbox 1, port A to port B.
            a_op(bad_cs, bad_cs, 1'b1, 1'b1, d);
            chk(mb1_flag_n === 1'b1, "R9 gated a write", mb1_flag_n, 1);
            a_op(1'b0, 1'b1, 1'b1, 1'b1, d);
            chk(mb1_flag_n === 1'b0, "R2 mb1 flag low", mb1_flag_n, 0);
            a_op(1'b0, 1'b1, 1'b1, 1'b1, ~d);
            wait_b(XWAIT);
            chk(b_dout === d, "R2 R3 mb1 data", b_dout, d);
            b_op(1'b0, 1'b1, 1'b0, other_siz, '0);
            chk(mb1_flag_n === 1'b0, "R5 wrong size read", mb1_flag_n, 0);
            b_op(bad_cs, bad_cs, 1'b0, 2'b11, '0);
            chk(mb1_flag_n === 1'b0, "R9 gated b read", mb1_flag_n, 0);
            b_op(1'b0, 1'b1, 1'b0, 2'b11, '0);
            chk(mb1_flag_n === 1'b1, "R4 mb1 cleared", mb1_flag_n, 1);
            wait_a(XWAIT);

            // Mailbox 2, port B to port A.
            b_op(1'b0, 1'b1, 1'b1, other_siz, e);
            chk(mb2_flag_n === 1'b1, "R6 wrong size write", mb2_flag_n, 1);
            b_op(bad_cs, bad_cs, 1'b1, 2'b11, e);
            chk(mb2_flag_n === 1'b1, "R9 gated b write", mb2_flag_n, 1);
            b_op(1'b0, 1'b1, 1'b1, 2'b11, e);
            chk(mb2_flag_n === 1'b0, "R6 mb2 flag low", mb2_flag_n, 0);
            b_op(1'b0, 1'b1, 1'b1, 2'b11, d);
            wait_a(XWAIT);
            chk(a_dout === e, "R6 R7 mb2 data", a_dout, e);
            a_op(1'b0, 1'b1, 1'b0, 1'b0, '0);
            chk(mb2_flag_n === 1'b0, "R8 unselected read", mb2_flag_n, 0);
            a_op(bad_cs, bad_cs, 1'b0, 1'b1, '0);
            chk(mb2_flag_n === 1'b0, "R9 gated a read", mb2_flag_n, 0);
            a_op(1'b0, 1'b1, 1'b0, 1'b1, '0);
            chk(mb2_flag_n === 1'b1, "R8 mb2 cleared", mb2_flag_n, 1);
            wait_b(XWAIT);
        end

        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
            $finish;
        end
    end

    initial begin
        #1_000_000;
        if (!done) begin
            done = 1'b1;
            nvec++;
            nbad++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
            $finish;
        end
    end
endmodule